// File: doc/BRIEF.md
# Card Controller Serial Control Port

This block is a byte-oriented I2C slave that gives a host access to one 8-bit control register of a smart card interface controller. It oversamples SCL and SDA with a fast system clock and frames each transfer from its START and STOP conditions. It accepts the transfer only when the 7-bit address matches, acknowledges each byte it takes, and on reads shifts the register out. SDA is open-drain: the block only ever pulls the line low.

The 7-bit address is the fixed upper nibble 0b0100 with three strap pins below it, strap[2] as the most significant, so eight such controllers can share one bus. The register fields drive the card controller directly. The warm-reset request bit is set by the host and cleared by the card side when the card starts to answer or is declared mute.

Top module: `cardctl_i2c_slave`

## Requirements
- R1: After reset the register reads 0x00, so every field output is low and `sda_oe` is low.
- R2: For an address byte whose top seven bits equal {0b0100, strap[2], strap[1], strap[0]}, the slave pulls SDA low during the ninth clock. The last bit is R/W, where 0 means write and 1 means read.
- R3: A non-matching address gets no ACK. The following bytes are neither acknowledged nor stored until the next START.
- R4: On a write, the data byte is ACKed and loaded into the register. The register maps to the outputs as: bit0 `card_on`, bit1 `warm_req`, bit2 `vsel_3v` (1 = 3 V), bit3 `clk_halt`, bit4 `clk_halt_hi`, bits 6:5 `clk_div`, bit7 `io_en`.
- R5: Within one write transfer each further data byte is also ACKed and replaces the register, so the last byte wins.
- R6: On a read, the register is shifted out MSB first, one bit per SCL clock.
- R7: After a read byte, a master ACK (SDA low) starts another copy of the register. A master NACK leaves SDA released until the next START.
- R8: A one-cycle pulse on `card_answer` or `card_mute` clears bit1 and leaves the other bits unchanged.
- R9: A STOP releases SDA. Clocks that arrive after a STOP and before a START are ignored.
- R10: Changing the strap pins moves the slave to the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap | input | 3 | Low three address bits |
| card_answer | input | 1 | Card began answering (clears warm request) |
| card_mute | input | 1 | Card declared mute (clears warm request) |
| card_on | output | 1 | Activate (1) / deactivate (0) |
| warm_req | output | 1 | Warm reset request |
| vsel_3v | output | 1 | Supply select, 1 = 3 V |
| clk_halt | output | 1 | Stop card clock |
| clk_halt_hi | output | 1 | Card clock stop level high |
| clk_div | output | 2 | Card clock rate select |
| io_en | output | 1 | Enable card I/O pass-through |

## Verification
A wrong framing state shows at `sda_oe` within one SCL period: an ACK goes missing, a stray ACK appears, or a read bit is wrong in the very next clock. A corrupted register or a bad warm-reset clear shows on the field outputs a few system clocks after the last data bit or the card event. Reads of the register expose the whole byte serially, so register errors also show on the bus.

// File: rtl/cardctl_i2c_slave.sv
module cardctl_i2c_slave #(
  parameter logic [3:0] ADDR_UPPER = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       card_answer,
  input  logic       card_mute,
  output logic       card_on,
  output logic       warm_req,
  output logic       vsel_3v,
  output logic       clk_halt,
  output logic       clk_halt_hi,
  output logic [1:0] clk_div,
  output logic       io_en
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d, scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tx, ctrl;
  logic       rw, mack, wr_now, idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign wr_now    = (st == S_WR) && scl_fall && (cnt == 4'd8);
  assign idle      = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WR:
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == S_WR) begin
              st     <= S_WACK;
              sda_oe <= 1'b1;
            end else if (sr[7:1] == {ADDR_UPPER, strap}) begin
              st     <= S_AACK;
              sda_oe <= 1'b1;
              rw     <= sr[0];
            end else begin
              st <= S_IDLE;
            end
          end
        S_AACK:
          if (scl_fall) begin
            if (rw) begin
              st     <= S_RD;
              tx     <= ctrl;
              sda_oe <= ~ctrl[7];
              cnt    <= 4'd1;
            end else begin
              st     <= S_WR;
              sda_oe <= 1'b0;
              cnt    <= '0;
            end
          end
        S_WACK:
          if (scl_fall) begin
            st     <= S_WR;
            sda_oe <= 1'b0;
            cnt    <= '0;
          end
        S_RD:
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              st     <= S_RACK;
              sda_oe <= 1'b0;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
        S_RACK:
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st     <= S_RD;
              tx     <= ctrl;
              sda_oe <= ~ctrl[7];
              cnt    <= 4'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ctrl <= 8'h00;
    else if (wr_now)
      ctrl <= sr;
    else if (card_answer || card_mute)
      ctrl[1] <= 1'b0;

  assign card_on     = ctrl[0];
  assign warm_req    = ctrl[1];
  assign vsel_3v     = ctrl[2];
  assign clk_halt    = ctrl[3];
  assign clk_halt_hi = ctrl[4];
  assign clk_div     = ctrl[6:5];
  assign io_en       = ctrl[7];
endmodule

module cardctl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       idle,
  input logic       sda_oe,
  input logic       card_answer,
  input logic       card_mute,
  input logic [7:0] ctrl
);
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
  assert_reg_changes_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> $past(scl_fall || card_answer || card_mute));
  assert_warm_set_by_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[1]) |-> $past(scl_fall));
  assert_warm_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (card_answer || card_mute) && !scl_fall |=> !ctrl[1]);
  assert_sda_moves_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind cardctl_i2c_slave cardctl_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .idle(idle), .sda_oe(sda_oe),
  .card_answer(card_answer), .card_mute(card_mute), .ctrl(ctrl)
);

// File: tb/cardctl_i2c_slave_bench.sv
module cardctl_i2c_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic card_answer = 1'b0, card_mute = 1'b0;
  logic sda_oe, sda_line;
  logic card_on, warm_req, vsel_3v, clk_halt, clk_halt_hi, io_en;
  logic [1:0] clk_div;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string req; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cardctl_i2c_slave u_cardctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .card_answer(card_answer), .card_mute(card_mute),
    .card_on(card_on), .warm_req(warm_req), .vsel_3v(vsel_3v), .clk_halt(clk_halt),
    .clk_halt_hi(clk_halt_hi), .clk_div(clk_div), .io_en(io_en));

  function automatic logic [7:0] regv();
    return {io_en, clk_div, clk_halt_hi, clk_halt, vsel_3v, warm_req, card_on};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      chk(e.req, {24'd0, g}, {24'd0, e.v});
    end

  task automatic w(int n); repeat (n) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q); endtask
  task automatic i2c_stop();  m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q); endtask
  task automatic send_bit(logic b); m_sda = b; w(Q); m_scl = 1; w(2*Q); m_scl = 0; w(Q); endtask
  task automatic recv_bit(output logic b);
    m_sda = 1; w(Q); m_scl = 1; w(Q); b = sda_line; w(Q); m_scl = 0; w(Q);
  endtask
  task automatic send_byte(logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask
  task automatic read_byte(logic master_ack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    got_q.push_back(v);
    send_bit(~master_ack);
  endtask

  initial begin
    logic ack;
    w(5); rst_n = 1; w(5);
    chk("R1 reg", {24'd0, regv()}, 0);
    chk("R1 sda", {31'd0, sda_oe}, 0);

    i2c_start(); send_byte({4'b0100, 3'b101, 1'b0}, ack); chk("R2 addr ack", {31'd0, ack}, 1);
    send_byte(8'hA5, ack); chk("R4 data ack", {31'd0, ack}, 1);
    i2c_stop(); w(4);
    chk("R4 reg", {24'd0, regv()}, 8'hA5);
    chk("R4 clk_div bits6:5", {30'd0, clk_div}, 2'b01);
    chk("R9 sda released", {31'd0, sda_oe}, 0);

    i2c_start(); send_byte({4'b0100, 3'b100, 1'b0}, ack); chk("R3 no ack", {31'd0, ack}, 0);
    send_byte(8'h3C, ack); chk("R3 data ignored ack", {31'd0, ack}, 0);
    i2c_stop(); w(4);
    chk("R3 reg kept", {24'd0, regv()}, 8'hA5);

    i2c_start(); send_byte(8'h4A, ack);
    send_byte(8'h12, ack); chk("R5 first ack", {31'd0, ack}, 1);
    send_byte(8'h5E, ack); chk("R5 second ack", {31'd0, ack}, 1);
    i2c_stop(); w(4);
    chk("R5 last wins", {24'd0, regv()}, 8'h5E);

    i2c_start(); send_byte(8'h4B, ack); chk("R2 read ack", {31'd0, ack}, 1);
    exp_q.push_back('{8'h5E, "R6 read"});
    read_byte(1'b0); w(2);
    chk("R7 released after nack", {31'd0, sda_oe}, 0);
    i2c_stop();

    i2c_start(); send_byte(8'h4B, ack);
    exp_q.push_back('{8'h5E, "R7 byte 1"});
    exp_q.push_back('{8'h5E, "R7 byte 2"});
    read_byte(1'b1); read_byte(1'b0); i2c_stop(); w(4);

    i2c_start(); send_byte(8'h4A, ack); send_byte(8'h03, ack); i2c_stop(); w(4);
    chk("R8 warm set", {24'd0, regv()}, 8'h03);
    card_answer = 1; w(1); card_answer = 0; w(3);
    chk("R8 answer clears", {24'd0, regv()}, 8'h01);
    i2c_start(); send_byte(8'h4A, ack); send_byte(8'hF6, ack); i2c_stop(); w(4);
    card_mute = 1; w(1); card_mute = 0; w(3);
    chk("R8 mute clears", {24'd0, regv()}, 8'hF4);

    for (int i = 7; i >= 0; i--) send_bit(i[0]);
    recv_bit(ack);
    chk("R9 no ack after stop", {31'd0, ack}, 1);
    w(4);
    chk("R9 reg kept", {24'd0, regv()}, 8'hF4);

    strap = 3'b000; w(4);
    i2c_start(); send_byte(8'h40, ack); chk("R10 new addr ack", {31'd0, ack}, 1);
    send_byte(8'h81, ack); i2c_stop(); w(4);
    chk("R10 reg", {24'd0, regv()}, 8'h81);
    i2c_start(); send_byte(8'h4A, ack); chk("R10 old addr no ack", {31'd0, ack}, 0);
    i2c_stop(); w(10);

    if (exp_q.size() != 0 || got_q.size() != 0)
      chk("R6 queue drained", exp_q.size() + got_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule